// File: doc/BRIEF.md
# Four-Channel Timer Input Capture

This block timestamps edges on four external pins against a free-running counter that lives outside it. Each pin is brought into the clock domain through its own synchronizer. A small two-state machine per pin then reports every rising and falling transition as a one-cycle pulse. A channel copies the counter into its capture register when an enabled edge kind occurs. If that channel's interrupt enable is also set, the copy sets a sticky status bit, and the status bits drive one shared interrupt line.

Software programs the unit through a plain register port. A write takes effect at the clock edge where `reg_wr_en` is high. The read data is combinational from `reg_addr`. The address map is:

- address 0: the control word.
- address 1: the interrupt status, which is write-one-to-clear.
- addresses 2 to 5: the four capture registers, which are read-only.
- addresses 6 and 7: unused, and read as zero.

The per-pin level tracker has two states. `LVL_LOW` moves to `LVL_HIGH` when the synchronized pin reads 1, and that transition emits the rise pulse. `LVL_HIGH` moves to `LVL_LOW` when the synchronized pin reads 0, and that transition emits the fall pulse. In every other case the tracker stays in its state and emits nothing. Reset places the tracker in `LVL_LOW`.

Top module: `icap_unit`

## Requirements
- R1: The control word sits at address 0 and is 12 bits wide; all of its bits reset to 0. For channel n, bit 3n enables capture on rising edges, bit 3n+1 enables capture on falling edges, and bit 3n+2 enables that channel's interrupt. Data bits 12 and above are discarded on write and read as 0. Addresses 6 and 7 read as 0.
- R2: A rising edge is a synchronized sample of 0 followed by a sample of 1. When bit 3n is set, a rising edge on pin n loads capture register n (address 2+n) with the counter value. The pin first changes before some clock edge E1; the synchronizer registers the new level at E1 and E2, and the load takes `cnt_val` as sampled at E3.
- R3: A falling edge is a synchronized sample of 1 followed by a sample of 0. When bit 3n+1 is set, a falling edge on pin n loads capture register n, with the same latency as R2.
- R4: When both edge enables of a channel are set, every edge on that pin produces exactly one load. This holds even for a pin that stays high for only one clock.
- R5: A channel whose edge enables are cleared ignores pin edges, and its capture register keeps the last captured value.
- R6: Status bit n (address 1, bit n) is set only by an actual load of capture register n, and only while bit 3n+2 is 1. An enabled interrupt on a channel with no edge enable never sets the bit.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a clear and a load that sets the bit fall on the same clock edge, the bit stays 1.
- R8: The `irq` output is 1 exactly when at least one status bit is 1.
- R9: The capture registers reset to 0, and writes to addresses 2 to 7 change no register. Pins are treated as low at reset, so a pin that is high out of reset counts as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | 32 | Free-running counter value to capture |
| cap_pin | input | 4 | Asynchronous capture pins, one per channel |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt, OR of the status bits |

## Verification
Each tracker's state should follow the synchronized pin. If a tracker fell out of step, the edge would be misclassified: a rising-only channel would capture on the falling edge instead, and the mismatch would show up in its capture register three edges after the pin moved. A status bit that was wrongly set or lost would change `irq` in the very next cycle. The bench rotates the read address every cycle, so any register that diverges from the reference is read back within eight cycles. It is also compared on the cycles where the ordering of a clear and a load matters.

// File: rtl/icap_pkg.sv
package icap_pkg;

    // Two-level tracker state for one synchronized pin
    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_state_e;

    // Control bits per channel and their positions in the group
    localparam int unsigned CH_BITS   = 3;
    localparam int unsigned BIT_RISE  = 0;
    localparam int unsigned BIT_FALL  = 1;
    localparam int unsigned BIT_IRQEN = 2;

    // Address map
    localparam int unsigned ADDR_CTRL = 0;
    localparam int unsigned ADDR_STAT = 1;
    localparam int unsigned ADDR_CAP0 = 2;

endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d_async;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/icap_edge_fsm.sv
module icap_edge_fsm
    import icap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    lvl_state_e st_q, st_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= LVL_LOW;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state and edge pulses
    always_comb begin
        st_d = st_q;
        rise = 1'b0;
        fall = 1'b0;
        unique case (st_q)
            LVL_LOW: begin
                if (lvl) begin
                    st_d = LVL_HIGH;
                    rise = 1'b1;
                end
            end
            LVL_HIGH: begin
                if (!lvl) begin
                    st_d = LVL_LOW;
                    fall = 1'b1;
                end
            end
            default: begin
                st_d = LVL_LOW;
            end
        endcase
    end
endmodule

// File: rtl/icap_chan.sv
module icap_chan #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic             fall,
    input  logic             en_rise,
    input  logic             en_fall,
    input  logic             en_irq,
    input  logic             clr,
    input  logic [CNT_W-1:0] cnt_val,
    output logic             load,
    output logic [CNT_W-1:0] cap_q,
    output logic             stat_q
);
    assign load = (rise && en_rise) || (fall && en_fall);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (load) begin
            cap_q <= cnt_val;
        end
    end

    // A load that raises the interrupt takes priority over a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= 1'b0;
        end else if (load && en_irq) begin
            stat_q <= 1'b1;
        end else if (clr) begin
            stat_q <= 1'b0;
        end
    end
endmodule

// File: rtl/icap_unit.sv
module icap_unit
    import icap_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic [NUM_CH-1:0] cap_pin,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    localparam int unsigned CTRL_W = CH_BITS * NUM_CH;

    logic [CTRL_W-1:0]               ctrl_q;
    logic [NUM_CH-1:0]               pin_s;
    logic [NUM_CH-1:0]               rise_v;
    logic [NUM_CH-1:0]               fall_v;
    logic [NUM_CH-1:0]               load_v;
    logic [NUM_CH-1:0]               stat_q;
    logic [NUM_CH-1:0][CNT_W-1:0]    cap_q;
    logic                            wr_ctrl;
    logic                            wr_stat;

    assign wr_ctrl = reg_wr_en && (reg_addr == ADDR_W'(ADDR_CTRL));
    assign wr_stat = reg_wr_en && (reg_addr == ADDR_W'(ADDR_STAT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= reg_wdata[CTRL_W-1:0];
        end
    end

    icap_sync #(
        .WIDTH  (NUM_CH),
        .STAGES (2)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (cap_pin),
        .q_sync  (pin_s)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        icap_edge_fsm edge_i (
            .clk   (clk),
            .rst_n (rst_n),
            .lvl   (pin_s[n]),
            .rise  (rise_v[n]),
            .fall  (fall_v[n])
        );

        icap_chan #(
            .CNT_W (CNT_W)
        ) chan_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .rise    (rise_v[n]),
            .fall    (fall_v[n]),
            .en_rise (ctrl_q[CH_BITS*n + BIT_RISE]),
            .en_fall (ctrl_q[CH_BITS*n + BIT_FALL]),
            .en_irq  (ctrl_q[CH_BITS*n + BIT_IRQEN]),
            .clr     (wr_stat && reg_wdata[n]),
            .cnt_val (cnt_val),
            .load    (load_v[n]),
            .cap_q   (cap_q[n]),
            .stat_q  (stat_q[n])
        );
    end

    // Read multiplexer
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(ADDR_CTRL)) begin
            reg_rdata[CTRL_W-1:0] = ctrl_q;
        end else if (reg_addr == ADDR_W'(ADDR_STAT)) begin
            reg_rdata[NUM_CH-1:0] = stat_q;
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (reg_addr == ADDR_W'(ADDR_CAP0 + i)) begin
                    reg_rdata[CNT_W-1:0] = cap_q[i];
                end
            end
        end
    end

    assign irq = |stat_q;
endmodule

// File: rtl/icap_unit_chk.sv
module icap_unit_chk
    import icap_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 3
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [ADDR_W-1:0]            reg_addr,
    input logic [DATA_W-1:0]            reg_rdata,
    input logic [NUM_CH-1:0]            rise_v,
    input logic [NUM_CH-1:0]            fall_v,
    input logic [NUM_CH-1:0]            load_v,
    input logic [NUM_CH-1:0]            stat_q,
    input logic [CH_BITS*NUM_CH-1:0]    ctrl_q,
    input logic [NUM_CH-1:0][CNT_W-1:0] cap_q
);
    localparam int unsigned CTRL_W = CH_BITS * NUM_CH;

    // R1: bits above the control word read as zero
    p_ctrl_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(ADDR_CTRL)) |-> ((reg_rdata >> CTRL_W) == '0));

    for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
        // R4: one edge kind per cycle at most
        p_one_edge_kind_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0({rise_v[n], fall_v[n]}));

        // R5 / R9: capture register moves only on a load
        p_cap_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !load_v[n] |=> $stable(cap_q[n]));

        // R6: status cannot rise without an interrupt-enabled load
        p_stat_needs_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!(load_v[n] && ctrl_q[CH_BITS*n + BIT_IRQEN]) && !stat_q[n]) |=> !stat_q[n]);

        // R7: an interrupt-enabled load always leaves the bit set
        p_load_sets_stat_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (load_v[n] && ctrl_q[CH_BITS*n + BIT_IRQEN]) |=> stat_q[n]);
    end
endmodule

bind icap_unit icap_unit_chk #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .rise_v    (rise_v),
    .fall_v    (fall_v),
    .load_v    (load_v),
    .stat_q    (stat_q),
    .ctrl_q    (ctrl_q),
    .cap_q     (cap_q)
);

// File: tb/icap_unit_tb_top.sv
`timescale 1ns/1ps
module icap_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cnt_val = 32'h0000_1000;
    logic [3:0]  cap_pin = 4'h0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        irq;

    always #2.5 clk = ~clk;

    always @(negedge clk) cnt_val <= cnt_val + 32'd7;

    icap_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_val   (cnt_val),
        .cap_pin   (cap_pin),
        .reg_wr_en (reg_wr_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    int    n_checks = 0;
    int    n_fail = 0;
    int    rd_idx = 0;
    string cur_req = "R9";

    // ---------------- reference model ----------------
    logic [11:0] m_ctrl;
    logic [31:0] m_cap [4];
    logic [3:0]  m_stat;
    logic [3:0]  hist [$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ctrl = '0;
            m_stat = '0;
            for (int i = 0; i < 4; i++) m_cap[i] = '0;
            hist = '{4'h0, 4'h0, 4'h0};
        end else begin
            logic [3:0] older;
            logic [3:0] newer;
            older = hist[2];
            newer = hist[1];
            for (int i = 0; i < 4; i++) begin
                bit up, dn, ld;
                up = !older[i] && newer[i];
                dn = older[i] && !newer[i];
                ld = (up && m_ctrl[3*i]) || (dn && m_ctrl[3*i+1]);
                if (ld) m_cap[i] = cnt_val;
                if (ld && m_ctrl[3*i+2]) m_stat[i] = 1'b1;
                else if (reg_wr_en && reg_addr == 3'd1 && reg_wdata[i]) m_stat[i] = 1'b0;
            end
            if (reg_wr_en && reg_addr == 3'd0) m_ctrl = reg_wdata[11:0];
            hist.push_front(cap_pin);
            void'(hist.pop_back());
        end
    end

    function automatic logic [31:0] mdl_read(input logic [2:0] a);
        case (a)
            3'd0:    return {20'h0, m_ctrl};
            3'd1:    return {28'h0, m_stat};
            3'd2:    return m_cap[0];
            3'd3:    return m_cap[1];
            3'd4:    return m_cap[2];
            3'd5:    return m_cap[3];
            default: return 32'h0;
        endcase
    endfunction

    // ---------------- checking and driving ----------------
    task automatic compare();
        logic [31:0] exp_rd;
        logic        exp_irq;
        exp_rd  = mdl_read(reg_addr);
        exp_irq = |m_stat;
        n_checks++;
        if (reg_rdata !== exp_rd) begin
            n_fail++;
            $display("FAIL %s rdata addr %0d: got %h expected %h", cur_req, reg_addr, reg_rdata, exp_rd);
        end
        n_checks++;
        if (irq !== exp_irq) begin
            n_fail++;
            $display("FAIL R8 irq (%s): got %b expected %b", cur_req, irq, exp_irq);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        compare();
        reg_wr_en = 1'b0;
        reg_wdata = '0;
        rd_idx    = (rd_idx + 1) % 8;
        reg_addr  = rd_idx[2:0];
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        reg_wr_en = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        tick();
    endtask

    task automatic look(input logic [2:0] a);
        reg_addr = a;
        tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9 / R1: reset values across the whole map
        cur_req = "R9";
        idle(9);

        // R1: control field layout, upper bits dropped
        cur_req = "R1";
        wr_reg(3'd0, 32'hFFFF_F000);
        look(3'd0);
        wr_reg(3'd0, 32'hABC5_0924);
        look(3'd0);
        look(3'd6);
        look(3'd7);
        wr_reg(3'd0, 32'h0);

        // R2: rising-only on every channel
        cur_req = "R2";
        wr_reg(3'd0, 32'h249);
        cap_pin = 4'b0101; idle(8);
        cap_pin = 4'b1111; idle(8);
        cap_pin = 4'b0000; idle(8);
        cap_pin = 4'b1010; idle(8);

        // R3: falling-only on every channel
        cur_req = "R3";
        wr_reg(3'd0, 32'h492);
        cap_pin = 4'b0110; idle(8);
        cap_pin = 4'b0001; idle(8);
        cap_pin = 4'b1111; idle(8);
        cap_pin = 4'b0000; idle(8);

        // R4: both edges, including one-cycle pulses
        cur_req = "R4";
        wr_reg(3'd0, 32'h6DB);
        for (int k = 0; k < 6; k++) begin
            cap_pin = 4'(k * 5 + 3); idle(3);
        end
        cap_pin = 4'b0100; tick();
        cap_pin = 4'b0000; idle(8);
        cap_pin = 4'b1001; tick();
        cap_pin = 4'b0110; tick();
        cap_pin = 4'b0000; idle(8);

        // R6: interrupt only on an actual load
        cur_req = "R6";
        wr_reg(3'd1, 32'hF);
        wr_reg(3'd0, 32'h13B);
        cap_pin = 4'b1111; idle(8);
        look(3'd1);
        cap_pin = 4'b0000; idle(8);
        look(3'd1);

        // R8: irq follows the status bits
        cur_req = "R8";
        wr_reg(3'd1, 32'h0);
        look(3'd1);
        wr_reg(3'd1, 32'h2);
        look(3'd1);

        // R7: clear and load on the same edge; load wins
        cur_req = "R7";
        wr_reg(3'd0, 32'h038);
        cap_pin = 4'b0010;
        tick();
        tick();
        wr_reg(3'd1, 32'h2);
        look(3'd1);
        wr_reg(3'd1, 32'h2);
        look(3'd1);
        cap_pin = 4'b0000; idle(8);
        wr_reg(3'd1, 32'h0);
        look(3'd1);
        wr_reg(3'd1, 32'hF);
        look(3'd1);

        // R5: disabled channels ignore edges and keep values
        cur_req = "R5";
        wr_reg(3'd0, 32'h924);
        cap_pin = 4'b1111; idle(8);
        cap_pin = 4'b0000; idle(8);
        for (int a = 1; a < 6; a++) look(3'(a));

        // R9: writes to read-only and unused addresses
        cur_req = "R9";
        for (int a = 2; a < 8; a++) wr_reg(3'(a), 32'hDEAD_BEEF);
        idle(8);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule